// File: doc/BRIEF.md
# Dual-Port Drive Interrupt Gate

This block sits on an expansion card that carries two disk-drive ports. Each drive raises its own interrupt line. The block brings each line into the card clock domain and keeps a per-port enable latch. It drives one combined interrupt request toward the host, plus a pending flag that shows whether any port is asserting, masked or not. Lines from a port with no drive attached float. Software keeps such a port masked so that false requests cannot reach the host.

Software reaches the block over a simple synchronous register bus with an address, a read strobe, a write strobe and 8-bit data. Each port has two addresses. The first is a mask address: an access to it changes the enable latch, and the data is ignored. The second is a status address that returns the port's synchronised line in bit 0. The defaults place port 0 at 0x2200 (mask) and 0x2290 (status), and port 1 at 0x3200 and 0x3290. A parameter stride of 0x1000 separates the ports.

Top module: `drvirq_gate`

## Requirements
- R1: While `rst` is high and after it falls, both enables are cleared, and `irq_req`, `irq_pending` and `bus_rdata` are 0.
- R2: A write strobe to a port's mask address (0x2200 for port 0, 0x3200 for port 1) enables that port, whatever the value on `bus_wdata`.
- R3: A read strobe to a port's mask address disables that port, and the read returns 0x00.
- R4: A read of a port's status address (0x2290 or 0x3290) returns the synchronised line of that port in bit 0, whether or not the port is enabled. Bits 7 to 1 are 0.
- R5: `irq_pending` is the OR over both ports of the synchronised lines, regardless of the enables.
- R6: `irq_req` is the OR over both ports of (synchronised line AND enable). A masked port with an asserted line never raises `irq_req`.
- R7: A change on `drv_irq` passes two synchroniser flops and then an output register. It appears on `irq_pending` after the third rising edge, and not after the second.
- R8: A read strobe and a write strobe to the same mask address in the same cycle leave that port disabled.
- R9: Accesses to any other address do not change either enable. Reads of unmapped addresses return 0x00.
- R10: An access to one port's mask address leaves the other port's enable unchanged.
- R11: `bus_rdata` is updated at the edge that samples a read strobe and is valid in the following cycle. The bus has no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data (ignored by every register) |
| bus_rdata | output | 8 | Registered read data |
| drv_irq | input | 2 | Raw interrupt line per drive port, asynchronous |
| irq_req | output | 1 | Combined, masked interrupt request |
| irq_pending | output | 1 | OR of both synchronised lines, unmasked |

## Verification
The bench first drives both lines high with both ports masked. This separates the unmasked pending path and the status readback from the masked request path. Next, a single line rises on its own, and the bench samples `irq_pending` on the cycle before it is due and on the cycle it is due, which pins down the synchroniser depth. It then enables one port, disables it and re-enables it with different data values. Alongside these it issues strobes to the status address, to an unmapped address, to the other port's address and a simultaneous read and write. Each of these shows whether an access leaves the enable alone, flips it, or flips the wrong port.

// File: rtl/drvirq_pkg.sv
package drvirq_pkg;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned NUM_PORTS   = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] MASK_BASE   = 16'h2200;
  localparam logic [ADDR_W-1:0] STAT_OFS    = 16'h0090;
  localparam logic [ADDR_W-1:0] PORT_STRIDE = 16'h1000;

  function automatic logic [ADDR_W-1:0] mask_addr_of(input int unsigned p);
    return MASK_BASE + ADDR_W'(p) * PORT_STRIDE;
  endfunction

  function automatic logic [ADDR_W-1:0] stat_addr_of(input int unsigned p);
    return mask_addr_of(p) + STAT_OFS;
  endfunction
endpackage

// File: rtl/drvirq_sync.sv
module drvirq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else if (STAGES == 1) chain_q <= async_in[b];
      else chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain_q[LAST];
  end
endmodule

// File: rtl/drvirq_port.sv
module drvirq_port #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 16'h2200,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h2290
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              line_sync,
  output logic              en,
  output logic              stat_rd_hit,
  output logic              stat_bit
);
  logic mask_hit;
  logic en_q;

  assign mask_hit    = (bus_addr == MASK_ADDR);
  assign stat_rd_hit = bus_rd && (bus_addr == STAT_ADDR);
  assign stat_bit    = line_sync;

  // Disable by read has priority over enable by write (safe side).
  always_ff @(posedge clk) begin
    if (rst)                      en_q <= 1'b0;
    else if (bus_rd && mask_hit)  en_q <= 1'b0;
    else if (bus_wr && mask_hit)  en_q <= 1'b1;
  end
  assign en = en_q;

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(bus_wr && !bus_rd && mask_hit));
  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && mask_hit) |=> !en_q);
  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(mask_hit && (bus_rd || bus_wr)) |=> $stable(en_q));
endmodule

// File: rtl/drvirq_readmux.sv
module drvirq_readmux #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_rd,
  input  logic [NUM_PORTS-1:0] stat_rd_hit,
  input  logic [NUM_PORTS-1:0] stat_bits,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] rdata_q;
  logic              bit0_d;

  assign bit0_d = |(stat_rd_hit & stat_bits);

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= {{(DATA_W-1){1'b0}}, bit0_d};
  end
  assign rdata = rdata_q;

  // R4
  rdata_hi_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_q[DATA_W-1:1] == '0);
endmodule

// File: rtl/drvirq_gate.sv
module drvirq_gate
  import drvirq_pkg::*;
#(
  parameter int unsigned P_ADDR_W  = ADDR_W,
  parameter int unsigned P_DATA_W  = DATA_W,
  parameter int unsigned P_PORTS   = NUM_PORTS,
  parameter int unsigned P_SYNC    = SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [P_ADDR_W-1:0] bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [P_DATA_W-1:0] bus_wdata,
  output logic [P_DATA_W-1:0] bus_rdata,
  input  logic [P_PORTS-1:0]  drv_irq,
  output logic                irq_req,
  output logic                irq_pending
);
  logic [P_PORTS-1:0] line_sync;
  logic [P_PORTS-1:0] en;
  logic [P_PORTS-1:0] stat_rd_hit;
  logic [P_PORTS-1:0] stat_bits;
  logic               irq_req_q;
  logic               pend_q;
  wire                unused_wdata = ^bus_wdata;

  drvirq_sync #(.WIDTH(P_PORTS), .STAGES(P_SYNC)) sync_i (
    .clk(clk), .rst(rst), .async_in(drv_irq), .sync_out(line_sync)
  );

  for (genvar p = 0; p < P_PORTS; p++) begin : g_port
    drvirq_port #(
      .ADDR_W(P_ADDR_W),
      .MASK_ADDR(P_ADDR_W'(mask_addr_of(p))),
      .STAT_ADDR(P_ADDR_W'(stat_addr_of(p)))
    ) port_i (
      .clk(clk), .rst(rst),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .line_sync(line_sync[p]),
      .en(en[p]),
      .stat_rd_hit(stat_rd_hit[p]),
      .stat_bit(stat_bits[p])
    );
  end

  drvirq_readmux #(.NUM_PORTS(P_PORTS), .DATA_W(P_DATA_W)) rmux_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd),
    .stat_rd_hit(stat_rd_hit), .stat_bits(stat_bits),
    .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      irq_req_q <= |(line_sync & en);
      pend_q    <= |line_sync;
    end
  end
  assign irq_req     = irq_req_q;
  assign irq_pending = pend_q;

  // R6
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(|en) |-> !irq_req_q);
  // R5
  irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req_q |-> pend_q);
endmodule

// File: tb/drvirq_gate_tb_top.sv
module drvirq_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [1:0]  drv_irq = '0;
  logic        irq_req;
  logic        irq_pending;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  drvirq_gate dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .drv_irq(drv_irq), .irq_req(irq_req), .irq_pending(irq_pending)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected read item per sampled read strobe.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && !rst) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R11: read data with no expected item, actual=%0h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic bus_rdwr(input logic [15:0] a, input string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'hFF;
    exp_q.push_back(8'h00); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq_req in reset", {7'b0, irq_req}, 8'h00);
    check("R1 pending in reset", {7'b0, irq_pending}, 8'h00);
    check("R1 rdata in reset", bus_rdata, 8'h00);
    @(negedge clk); rst = 1'b0;
    settle(1);
    check("R1 irq_req after reset", {7'b0, irq_req}, 8'h00);

    // Both lines float high, both masked.
    drv_irq = 2'b11;
    settle(4);
    check("R6 masked lines give no request", {7'b0, irq_req}, 8'h00);
    check("R5 pending unmasked", {7'b0, irq_pending}, 8'h01);
    bus_read(16'h2290, 8'h01, "R4 status port0 masked");
    bus_read(16'h3290, 8'h01, "R4 status port1 masked");

    // Latency of a single rising line.
    drv_irq = 2'b00;
    settle(4);
    check("R5 pending low", {7'b0, irq_pending}, 8'h00);
    drv_irq = 2'b01;
    settle(2);
    check("R7 not visible after two edges", {7'b0, irq_pending}, 8'h00);
    settle(1);
    check("R7 visible after three edges", {7'b0, irq_pending}, 8'h01);
    bus_read(16'h3290, 8'h00, "R4 status port1 low");

    // Enable port1 only: port0 line high must not pass.
    bus_write(16'h3200, 8'h00);
    settle(1);
    check("R10 port1 enable leaves port0 masked", {7'b0, irq_req}, 8'h00);
    bus_write(16'h2200, 8'hA5);
    settle(1);
    check("R2 write enables port0", {7'b0, irq_req}, 8'h01);

    // Read of mask disables.
    bus_read(16'h2200, 8'h00, "R3 mask read data");
    settle(1);
    check("R3 mask read disables port0", {7'b0, irq_req}, 8'h00);
    bus_read(16'h2290, 8'h01, "R4 status while masked");

    // Port1 still enabled: its line rises.
    drv_irq = 2'b11;
    settle(4);
    check("R10 port1 still enabled", {7'b0, irq_req}, 8'h01);
    drv_irq = 2'b01;
    settle(4);
    check("R6 port0 masked, port1 low", {7'b0, irq_req}, 8'h00);

    // Other addresses do not change enables.
    bus_write(16'h2290, 8'hFF);
    bus_write(16'h2201, 8'hFF);
    bus_write(16'h4200, 8'hFF);
    settle(1);
    check("R9 foreign writes leave port0 masked", {7'b0, irq_req}, 8'h00);
    bus_read(16'h1234, 8'h00, "R9 unmapped read");
    bus_read(16'h2291, 8'h00, "R9 near-status read");

    // Re-enable with other data, then collide read and write.
    bus_write(16'h2200, 8'h5A);
    settle(1);
    check("R2 write 5A enables port0", {7'b0, irq_req}, 8'h01);
    bus_read(16'h3200, 8'h00, "R3 mask read port1");
    settle(1);
    check("R10 port1 disable keeps port0", {7'b0, irq_req}, 8'h01);
    bus_rdwr(16'h2200, "R8 collide read data");
    settle(1);
    check("R8 read wins over write", {7'b0, irq_req}, 8'h00);
    drv_irq = 2'b10;
    settle(4);
    check("R8 port1 disabled too", {7'b0, irq_req}, 8'h00);
    check("R5 pending from port1", {7'b0, irq_pending}, 8'h01);

    settle(2);
    if (exp_q.size() != 0) begin
      n_checks++; n_errors++;
      $display("FAIL R11: %0d reads unanswered actual=%0d expected=0", exp_q.size(), exp_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule